// File: doc/BRIEF.md
# Flash Read Wait-State Controller

This controller sits between a bus master and a flash array interface and decides how long each access takes. A read whose address continues the current sequential stream finishes with no added cycles. A read that breaks the stream is stretched by a programmable number of wait cycles, so that the array has time to start a new burst. Writes finish either in one cycle or with one extra wait cycle, chosen by a single configuration bit.

The master raises `req_i` together with `addr_i` and `wr_i`, and keeps all three steady until it sees `rdy_o` high at a clock edge. The array side receives a strobe, a write flag and the address as pass-through copies of the request. It can hold back completion with `arr_ready_i`. The wait settings are sampled only when an access starts, so reprogramming them never disturbs an access already in progress. The expected read setting is one wait for flash clocks up to 66 MHz and two waits above that. The full 0 to 3 range of the field is honoured.

Top module: `fws_ctrl`

## Requirements
- R1: After reset, `rdy_o` is low while no request is present. The first read after reset counts as non-sequential and waits `cfg_rd_ws_i` cycles.
- R2: A read whose address equals the last completed read address plus 4 completes at zero wait: `rdy_o` is high in the first cycle of the request, provided `arr_ready_i` is high.
- R3: A non-sequential read holds `rdy_o` low for exactly `cfg_rd_ws_i` cycles and raises it in the next cycle.
- R4: Every value of the 2-bit read wait field is honoured: 0 gives zero wait, 1, 2 and 3 give that many wait cycles.
- R5: A write with `cfg_wr_ws_i` = 0 completes in its first cycle. A write with `cfg_wr_ws_i` = 1 has one wait cycle.
- R6: The first read after any write is non-sequential, even when its address is the last read address plus 4.
- R7: A change to `cfg_rd_ws_i` or `cfg_wr_ws_i` during an access does not change that access's length. The new value applies from the next access.
- R8: `rdy_o` is never high while `arr_ready_i` is low. An access ends in the first cycle in which its wait cycles have elapsed and `arr_ready_i` is high.
- R9: `arr_stb_o` follows `req_i`, and `arr_we_o` and `arr_addr_o` follow `wr_i` and `addr_i`.
- R10: A read to any address other than the last read address plus 4 is non-sequential, including a repeat of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, held until ready |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (32) | Byte address of the access |
| rdy_o | output | 1 | Access completes in this cycle |
| cfg_rd_ws_i | input | CW (2) | Wait cycles for non-sequential reads |
| cfg_wr_ws_i | input | 1 | 1 = writes take one wait cycle |
| arr_stb_o | output | 1 | Strobe to the flash array |
| arr_we_o | output | 1 | Write flag to the flash array |
| arr_addr_o | output | AW (32) | Address to the flash array |
| arr_ready_i | input | 1 | Array can complete the access |

## Verification
A stale or wrong last-read record shows up on the first read after the corruption. The access either finishes at once when it should have waited, or waits when it should not. Either way the cycle count from request to ready is off. A wait counter that loses its place shows up on that same access as a ready that comes early or late, or never if the counter hangs. The bench measures the wait cycles of every access against a queue of expected counts, so each such fault appears within one access.

// File: rtl/fws_pkg.sv
package fws_pkg;

    // Classification of the access presented at the master port
    typedef enum logic [1:0] {
        ACC_SEQ_RD  = 2'd0,
        ACC_NSEQ_RD = 2'd1,
        ACC_WR      = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/fws_seq_det.sv
module fws_seq_det #(
    parameter int AW     = 32,
    parameter int STRIDE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          rd_done_i,
    input  logic          wr_done_i,
    output logic          is_seq_o
);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] last;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (rd_done_i) begin
            trk_d.vld  = 1'b1;
            trk_d.last = addr_i;
        end else if (wr_done_i) begin
            trk_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign is_seq_o = trk_q.vld && (addr_i == trk_q.last + AW'(STRIDE));

    // A finished write leaves no sequential stream behind it
    p_wr_breaks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done_i && !rd_done_i |=> !is_seq_o);

endmodule

// File: rtl/fws_wait_cnt.sv
module fws_wait_cnt #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [CW-1:0] waits_i,
    input  logic          arr_ready_i,
    output logic          rdy_o,
    output logic          busy_o
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rdy_o = 1'b0;
        if (!st_q.busy) begin
            if (req_i) begin
                if (waits_i == '0 && arr_ready_i) begin
                    rdy_o = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = (waits_i == '0) ? '0 : waits_i - CW'(1);
                end
            end
        end else begin
            if (st_q.cnt == '0) begin
                if (arr_ready_i) begin
                    rdy_o     = 1'b1;
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;

    // While the latched count is still running, ready stays low
    p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && st_q.cnt != '0 |-> !rdy_o);

    // An access in flight keeps its request raised
    p_busy_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> req_i);

    // The latched count only moves down or clears: config changes cannot extend it
    p_cnt_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && st_q.cnt != '0 |=> st_q.busy && st_q.cnt < $past(st_q.cnt));

endmodule

// File: rtl/fws_ctrl.sv
module fws_ctrl #(
    parameter int AW = 32,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    output logic          rdy_o,
    input  logic [CW-1:0] cfg_rd_ws_i,
    input  logic          cfg_wr_ws_i,
    output logic          arr_stb_o,
    output logic          arr_we_o,
    output logic [AW-1:0] arr_addr_o,
    input  logic          arr_ready_i
);
    import fws_pkg::*;

    logic          is_seq;
    logic          busy;
    acc_kind_e     kind;
    logic [CW-1:0] waits;

    always_comb begin
        if (wr_i)        kind = ACC_WR;
        else if (is_seq) kind = ACC_SEQ_RD;
        else             kind = ACC_NSEQ_RD;
        case (kind)
            ACC_SEQ_RD:  waits = '0;
            ACC_NSEQ_RD: waits = cfg_rd_ws_i;
            default:     waits = cfg_wr_ws_i ? CW'(1) : '0;
        endcase
    end

    fws_seq_det #(.AW(AW), .STRIDE(4)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .rd_done_i (rdy_o && !wr_i),
        .wr_done_i (rdy_o && wr_i),
        .is_seq_o  (is_seq)
    );

    fws_wait_cnt #(.CW(CW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .waits_i     (waits),
        .arr_ready_i (arr_ready_i),
        .rdy_o       (rdy_o),
        .busy_o      (busy)
    );

    assign arr_stb_o  = req_i;
    assign arr_we_o   = wr_i;
    assign arr_addr_o = addr_i;

    p_rdy_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> req_i);

    p_rdy_arr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> arr_ready_i);

    p_seq_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !wr_i && is_seq && !busy && arr_ready_i |-> rdy_o);

    p_wr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && wr_i && !cfg_wr_ws_i && !busy && arr_ready_i |-> rdy_o);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !rdy_o |=> req_i && $stable(addr_i) && $stable(wr_i));

endmodule

// File: tb/fws_ctrl_test.sv
`timescale 1ns/1ps
module fws_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        rdy_o;
    logic [1:0]  cfg_rd_ws_i = 2'd1;
    logic        cfg_wr_ws_i = 1'b0;
    logic        arr_stb_o;
    logic        arr_we_o;
    logic [31:0] arr_addr_o;
    logic        arr_ready_i = 1'b1;

    always #4 clk = ~clk;

    fws_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .wr_i        (wr_i),
        .addr_i      (addr_i),
        .rdy_o       (rdy_o),
        .cfg_rd_ws_i (cfg_rd_ws_i),
        .cfg_wr_ws_i (cfg_wr_ws_i),
        .arr_stb_o   (arr_stb_o),
        .arr_we_o    (arr_we_o),
        .arr_addr_o  (arr_addr_o),
        .arr_ready_i (arr_ready_i)
    );

    typedef struct {
        int    waits;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   seen  = 0;
    bit   done  = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: counts wait cycles of each access, compares with the scoreboard
    always @(negedge clk) begin
        if (rst_n && req_i) begin
            if (!rdy_o) begin
                seen++;
            end else begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected completion", seen, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(seen == e.waits, e.tag, seen, e.waits);
                end
                seen = 0;
            end
        end
    end

    // Driver: called at posedge+1; stall = cycles arr_ready_i stays low;
    // poke = change the configuration in the second cycle of the access
    task automatic access(input logic [31:0] a, input bit w, input int exp,
                          input string tag, input int stall = 0, input bit poke = 1'b0);
        exp_t e;
        int   k;
        e.waits = exp;
        e.tag   = tag;
        exp_q.push_back(e);
        req_i  = 1'b1;
        wr_i   = w;
        addr_i = a;
        k = 0;
        forever begin
            arr_ready_i = (k >= stall);
            if (poke && k == 1) begin
                cfg_rd_ws_i = 2'd0;
                cfg_wr_ws_i = 1'b0;
            end
            @(negedge clk);
            if (k == 0) begin
                check(arr_stb_o == 1'b1, "R9 strobe", arr_stb_o, 1);
                check(arr_we_o == w, "R9 write flag", arr_we_o, w);
                check(arr_addr_o == a, "R9 address", arr_addr_o, a);
            end
            if (rdy_o) break;
            @(posedge clk); #1;
            k++;
        end
        @(posedge clk); #1;
        req_i       = 1'b0;
        arr_ready_i = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(rdy_o == 1'b0, "R1 reset ready low", rdy_o, 0);
        check(arr_stb_o == 1'b0, "R9 reset strobe low", arr_stb_o, 0);
        @(posedge clk); #1;

        access(32'h100, 1'b0, 1, "R1 first read after reset");
        access(32'h104, 1'b0, 0, "R2 sequential read");
        access(32'h108, 1'b0, 0, "R2 sequential read");
        access(32'h10C, 1'b0, 0, "R2 sequential read");
        access(32'h200, 1'b0, 1, "R10 jump read");
        access(32'h200, 1'b0, 1, "R10 same address repeat");
        cfg_rd_ws_i = 2'd2;
        access(32'h300, 1'b0, 2, "R3 two waits");
        access(32'h304, 1'b0, 0, "R2 sequential after two waits");
        cfg_rd_ws_i = 2'd3;
        access(32'h400, 1'b0, 3, "R4 three waits");
        cfg_rd_ws_i = 2'd0;
        access(32'h500, 1'b0, 0, "R4 zero waits");
        access(32'h504, 1'b1, 0, "R5 write zero wait");
        cfg_rd_ws_i = 2'd2;
        access(32'h504, 1'b0, 2, "R6 read after write");
        cfg_wr_ws_i = 1'b1;
        access(32'h600, 1'b1, 1, "R5 write one wait");
        access(32'h604, 1'b0, 2, "R6 read after write");
        cfg_rd_ws_i = 2'd3;
        access(32'h700, 1'b0, 3, "R7 config change mid read", 0, 1'b1);
        access(32'h800, 1'b0, 0, "R7 new config at next access");
        cfg_wr_ws_i = 1'b1;
        access(32'h900, 1'b1, 1, "R7 config change mid write", 0, 1'b1);
        access(32'h904, 1'b1, 0, "R7 new write config at next access");
        cfg_rd_ws_i = 2'd1;
        access(32'hA00, 1'b0, 1, "R3 one wait");
        access(32'hA04, 1'b0, 2, "R8 sequential stalled by array", 2);
        access(32'hB00, 1'b0, 3, "R8 stall longer than waits", 3);
        cfg_rd_ws_i = 2'd3;
        access(32'hC00, 1'b0, 3, "R8 waits longer than stall", 1);
        access(32'hC04, 1'b0, 0, "R2 sequential after stall");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R3 all accesses completed", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "R3 watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule